// File: doc/BRIEF.md
# Trap Level and Restricted-Mode Controller

This block holds a processor core's trap nesting level and decides which of three execution modes the core is in. The modes are normal running (RUN), a restricted recovery mode entered on any reset-class trap (RED), and a terminal error mode (ERR). Each cycle it takes at most one event: a reset-class trap request with a two-bit kind, a normal trap request, or a trap return. It updates the level, moves between modes and produces the vector address for the trap it takes.

In restricted mode every reset-class trap vectors into a fixed region. The virtual base is all ones above bit 28 and zeros below it. The physical image has ones from bit 28 up to the top physical bit. The block also overrides the core's translation enables on top of the values software holds. The override never replaces those values, so leaving restricted mode brings the software settings back on the next cycle. A data-side access attribute that forces noncacheable, strongly ordered accesses follows the effective data translation enable.

The mode state machine has three states: `TM_RUN`, `TM_RED` and `TM_ERR`. Its transitions are:
- `RUN->RED` and `RED->RED` on a reset-class trap.
- `RUN->ERR` and `RED->ERR` on a normal trap taken at the maximum level.
- `RED->RUN` on a trap return with a nonzero level.
- `ERR->RED` on a power-on or external reset-class trap.

Top module: `trapmode_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, the block is in RED with level = MAX_TL and ERR clear. `vec_va_o` = VA base + 0x20 and `vec_pa_o` = PA base + 0x20. `vec_take_o` is 0, both translation enables are 0 and `ncso_o` is 1.
- R2: In RUN, a normal trap with level < MAX_TL does the following on the next cycle. The level rises by one and `vec_take_o` pulses for one cycle. `vec_va_o` becomes `tba_i` if the level was 0, or `tba_i` + 0x4000 otherwise, and `vec_pa_o` becomes 0. The mode stays RUN.
- R3: A normal trap when level = MAX_TL, from RUN or RED, sets ERR and clears RED. The level does not change and no vector is taken (`vec_take_o` stays 0).
- R4: ERR is sticky. In ERR, normal traps, trap returns and reset-class requests of kind watchdog (1) or software (3) leave ERR set and the level unchanged. A request of kind power-on (0) or external (2) moves the block to RED with level = MAX_TL.
- R5: From RUN or RED, any reset-class request, including an external one while already in RED, enters RED with level = MAX_TL. Kinds are power-on 0, watchdog 1, external 2 and software 3. `vec_va_o` = VA base + 0x20 × (kind+1), and `vec_pa_o` = PA base + the same offset.
- R6: When several events arrive in one cycle, a reset-class request wins over a normal trap, and a normal trap wins over a trap return.
- R7: A trap return with level > 0 lowers the level by one and leaves RED for RUN. A trap return with level 0 is ignored.
- R8: `immu_en_o` equals `sw_immu_en_i` in RUN and is 0 in RED and ERR.
- R9: Entry into RED forces `dmmu_en_o` to 0. In RED, a write (`dxl_wr_i` = 1) with `dxl_wdata_i` = 1 lets `dmmu_en_o` follow `sw_dmmu_en_i`, and a write with `dxl_wdata_i` = 0 forces it to 0 again. Each new RED entry cancels the re-enable. In ERR, `dmmu_en_o` is 0.
- R10: `ncso_o` is 1 exactly when `dmmu_en_o` is 0.
- R11: On the cycle after a return out of RED, both enables equal the software settings again, even if data translation was still forced off in RED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Reset-class trap request |
| rst_kind_i | input | 2 | Reset kind: 0 power-on, 1 watchdog, 2 external, 3 software |
| trap_req_i | input | 1 | Normal trap request |
| trap_ret_i | input | 1 | Trap return event |
| tba_i | input | VA_W | Normal trap table base |
| sw_immu_en_i | input | 1 | Software-held instruction translation enable |
| sw_dmmu_en_i | input | 1 | Software-held data translation enable |
| dxl_wr_i | input | 1 | Write strobe for the restricted-mode data translation re-enable |
| dxl_wdata_i | input | 1 | Re-enable value written |
| tl_o | output | TL_W | Current trap level |
| red_o | output | 1 | Restricted mode active |
| err_o | output | 1 | Error mode active |
| vec_take_o | output | 1 | One-cycle pulse when a trap vector is taken |
| vec_va_o | output | VA_W | Virtual address of the last vector |
| vec_pa_o | output | PA_W | Physical image of the last restricted-mode vector (0 after a normal trap) |
| immu_en_o | output | 1 | Effective instruction translation enable |
| dmmu_en_o | output | 1 | Effective data translation enable |
| ncso_o | output | 1 | Force noncacheable, strongly ordered data accesses |

## Verification
A wrong mode state shows on `red_o`/`err_o` and on the translation enables in the same cycle it is registered. That is one clock after the event that caused it. A wrong level shows on `tl_o` at once. It also shows later as a wrong choice between a level increment and the move to ERR, and as the wrong nesting offset in the next normal vector. A stale data re-enable flag appears only as `dmmu_en_o`/`ncso_o` being wrong during a later RED stay. For that reason, the directed tests enter RED again after the flag has been set.

// File: rtl/trapmode_pkg.sv
package trapmode_pkg;

    typedef enum logic [1:0] {
        TM_RUN = 2'd0,
        TM_RED = 2'd1,
        TM_ERR = 2'd2
    } tm_state_e;

    typedef enum logic [2:0] {
        ACT_NONE = 3'd0,
        ACT_RST  = 3'd1,
        ACT_TRAP = 3'd2,
        ACT_ERR  = 3'd3,
        ACT_RET  = 3'd4
    } tm_act_e;

    localparam logic [1:0] RK_POR = 2'd0;
    localparam logic [1:0] RK_WDR = 2'd1;
    localparam logic [1:0] RK_XIR = 2'd2;
    localparam logic [1:0] RK_SIR = 2'd3;

    // Width of the zeroed low part of the fixed restricted-mode region
    localparam int FIXED_LOW_W = 28;
    // Spacing of reset vectors inside the region
    localparam int OFF_SHIFT   = 5;
    // Bit added to the normal vector when trapping from a nonzero level
    localparam int NEST_BIT    = 14;

    function automatic logic [7:0] red_offset(input logic [1:0] kind);
        return ({6'd0, kind} + 8'd1) << OFF_SHIFT;
    endfunction

endpackage

// File: rtl/tm_mode_fsm.sv
module tm_mode_fsm
    import trapmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req_i,
    input  logic [1:0] rst_kind_i,
    input  logic       trap_req_i,
    input  logic       trap_ret_i,
    input  logic       tl_max_i,
    input  logic       tl_zero_i,
    output tm_state_e  state_o,
    output tm_act_e    act_o
);

    tm_state_e state_q;
    tm_state_e state_d;
    tm_act_e   act_d;
    logic      wake_kind;

    assign wake_kind = (rst_kind_i == RK_POR) || (rst_kind_i == RK_XIR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TM_RED;
        end else begin
            state_q <= state_d;
        end
    end

    // transition and action decode
    always_comb begin
        state_d = state_q;
        act_d   = ACT_NONE;
        unique case (state_q)
            TM_ERR: begin
                if (rst_req_i && wake_kind) begin
                    state_d = TM_RED;
                    act_d   = ACT_RST;
                end
            end
            TM_RUN, TM_RED: begin
                if (rst_req_i) begin
                    state_d = TM_RED;
                    act_d   = ACT_RST;
                end else if (trap_req_i) begin
                    if (tl_max_i) begin
                        state_d = TM_ERR;
                        act_d   = ACT_ERR;
                    end else begin
                        act_d   = ACT_TRAP;
                    end
                end else if (trap_ret_i && !tl_zero_i) begin
                    state_d = TM_RUN;
                    act_d   = ACT_RET;
                end
            end
            default: begin
                state_d = TM_ERR;
                act_d   = ACT_NONE;
            end
        endcase
    end

    assign state_o = state_q;
    assign act_o   = act_d;

endmodule

// File: rtl/tm_level.sv
module tm_level
    import trapmode_pkg::*;
#(
    parameter int MAX_TL = 5,
    parameter int TL_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  tm_act_e         act_i,
    output logic [TL_W-1:0] tl_o,
    output logic            tl_max_o,
    output logic            tl_zero_o
);

    localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAX_TL);
    localparam logic [TL_W-1:0] TL_ONE = {{(TL_W-1){1'b0}}, 1'b1};

    logic [TL_W-1:0] tl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tl_q <= TL_TOP;
        end else begin
            unique case (act_i)
                ACT_RST:  tl_q <= TL_TOP;
                ACT_TRAP: tl_q <= tl_q + TL_ONE;
                ACT_RET:  tl_q <= tl_q - TL_ONE;
                default:  tl_q <= tl_q;
            endcase
        end
    end

    assign tl_o      = tl_q;
    assign tl_max_o  = (tl_q == TL_TOP);
    assign tl_zero_o = (tl_q == '0);

endmodule

// File: rtl/tm_vector.sv
module tm_vector
    import trapmode_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PA_W = 43
) (
    input  logic            clk,
    input  logic            rst_n,
    input  tm_act_e         act_i,
    input  logic [1:0]      rst_kind_i,
    input  logic            tl_zero_i,
    input  logic [VA_W-1:0] tba_i,
    output logic            take_o,
    output logic [VA_W-1:0] va_o,
    output logic [PA_W-1:0] pa_o
);

    localparam logic [VA_W-1:0] NEST_INC = {{(VA_W-1){1'b0}}, 1'b1} << NEST_BIT;

    logic [VA_W-1:0] va_q;
    logic [PA_W-1:0] pa_q;
    logic            take_q;

    function automatic logic [VA_W-1:0] fixed_va(input logic [1:0] kind);
        return {{(VA_W-FIXED_LOW_W){1'b1}}, {(FIXED_LOW_W-8){1'b0}}, red_offset(kind)};
    endfunction

    function automatic logic [PA_W-1:0] fixed_pa(input logic [1:0] kind);
        return {{(PA_W-FIXED_LOW_W){1'b1}}, {(FIXED_LOW_W-8){1'b0}}, red_offset(kind)};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q   <= fixed_va(RK_POR);
            pa_q   <= fixed_pa(RK_POR);
            take_q <= 1'b0;
        end else begin
            take_q <= 1'b0;
            unique case (act_i)
                ACT_RST: begin
                    va_q   <= fixed_va(rst_kind_i);
                    pa_q   <= fixed_pa(rst_kind_i);
                    take_q <= 1'b1;
                end
                ACT_TRAP: begin
                    va_q   <= tl_zero_i ? tba_i : (tba_i + NEST_INC);
                    pa_q   <= '0;
                    take_q <= 1'b1;
                end
                default: begin
                    va_q <= va_q;
                    pa_q <= pa_q;
                end
            endcase
        end
    end

    assign take_o = take_q;
    assign va_o   = va_q;
    assign pa_o   = pa_q;

endmodule

// File: rtl/tm_xlate.sv
module tm_xlate
    import trapmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tm_state_e state_i,
    input  tm_act_e   act_i,
    input  logic      dxl_wr_i,
    input  logic      dxl_wdata_i,
    input  logic      sw_immu_en_i,
    input  logic      sw_dmmu_en_i,
    output logic      immu_en_o,
    output logic      dmmu_en_o,
    output logic      ncso_o
);

    logic reen_q;
    logic d_allow;

    // re-enable flag: cleared on each reset-class entry, written only in RED
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reen_q <= 1'b0;
        end else if (act_i == ACT_RST) begin
            reen_q <= 1'b0;
        end else if ((state_i == TM_RED) && dxl_wr_i) begin
            reen_q <= dxl_wdata_i;
        end
    end

    // override is applied on top of the software settings, never stored
    always_comb begin
        unique case (state_i)
            TM_RUN:  d_allow = 1'b1;
            TM_RED:  d_allow = reen_q;
            default: d_allow = 1'b0;
        endcase
        immu_en_o = sw_immu_en_i && (state_i == TM_RUN);
        dmmu_en_o = sw_dmmu_en_i && d_allow;
        ncso_o    = !dmmu_en_o;
    end

endmodule

// File: rtl/trapmode_ctrl.sv
module trapmode_ctrl
    import trapmode_pkg::*;
#(
    parameter int MAX_TL = 5,
    parameter int VA_W   = 64,
    parameter int PA_W   = 43,
    localparam int TL_W  = $clog2(MAX_TL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_req_i,
    input  logic [1:0]      rst_kind_i,
    input  logic            trap_req_i,
    input  logic            trap_ret_i,
    input  logic [VA_W-1:0] tba_i,
    input  logic            sw_immu_en_i,
    input  logic            sw_dmmu_en_i,
    input  logic            dxl_wr_i,
    input  logic            dxl_wdata_i,
    output logic [TL_W-1:0] tl_o,
    output logic            red_o,
    output logic            err_o,
    output logic            vec_take_o,
    output logic [VA_W-1:0] vec_va_o,
    output logic [PA_W-1:0] vec_pa_o,
    output logic            immu_en_o,
    output logic            dmmu_en_o,
    output logic            ncso_o
);

    tm_state_e state;
    tm_act_e   act;
    logic      tl_max;
    logic      tl_zero;

    tm_mode_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_req_i  (rst_req_i),
        .rst_kind_i (rst_kind_i),
        .trap_req_i (trap_req_i),
        .trap_ret_i (trap_ret_i),
        .tl_max_i   (tl_max),
        .tl_zero_i  (tl_zero),
        .state_o    (state),
        .act_o      (act)
    );

    tm_level #(.MAX_TL(MAX_TL), .TL_W(TL_W)) level_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (act),
        .tl_o      (tl_o),
        .tl_max_o  (tl_max),
        .tl_zero_o (tl_zero)
    );

    tm_vector #(.VA_W(VA_W), .PA_W(PA_W)) vector_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (act),
        .rst_kind_i (rst_kind_i),
        .tl_zero_i  (tl_zero),
        .tba_i      (tba_i),
        .take_o     (vec_take_o),
        .va_o       (vec_va_o),
        .pa_o       (vec_pa_o)
    );

    tm_xlate xlate_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_i      (state),
        .act_i        (act),
        .dxl_wr_i     (dxl_wr_i),
        .dxl_wdata_i  (dxl_wdata_i),
        .sw_immu_en_i (sw_immu_en_i),
        .sw_dmmu_en_i (sw_dmmu_en_i),
        .immu_en_o    (immu_en_o),
        .dmmu_en_o    (dmmu_en_o),
        .ncso_o       (ncso_o)
    );

    assign red_o = (state == TM_RED);
    assign err_o = (state == TM_ERR);

endmodule

// File: rtl/trapmode_chk.sv
module trapmode_chk #(
    parameter int MAX_TL = 5,
    parameter int TL_W   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rst_req_i,
    input logic [1:0]      rst_kind_i,
    input logic            trap_req_i,
    input logic            trap_ret_i,
    input logic [TL_W-1:0] tl_o,
    input logic            red_o,
    input logic            err_o,
    input logic            vec_take_o,
    input logic            immu_en_o,
    input logic            dmmu_en_o
);

    localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAX_TL);

    // R2
    trap_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && !rst_req_i && trap_req_i && tl_o != TL_TOP)
        |=> (tl_o == TL_W'($past(tl_o) + 1'b1)) && vec_take_o);

    // R3
    trap_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && !rst_req_i && trap_req_i && tl_o == TL_TOP)
        |=> err_o && !red_o && !vec_take_o && (tl_o == TL_TOP));

    // R3
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(red_o && err_o));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(rst_req_i && (rst_kind_i == 2'd0 || rst_kind_i == 2'd2)))
        |=> err_o && (tl_o == $past(tl_o)));

    // R5
    rst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && rst_req_i) |=> red_o && (tl_o == TL_TOP));

    // R7
    ret_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && !rst_req_i && !trap_req_i && trap_ret_i && tl_o != '0)
        |=> !red_o && (tl_o == TL_W'($past(tl_o) - 1'b1)));

    // R8
    immu_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (red_o || err_o) |-> !immu_en_o);

    // R9
    dmmu_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(red_o) |-> !dmmu_en_o);

endmodule

bind trapmode_ctrl trapmode_chk #(.MAX_TL(MAX_TL), .TL_W(TL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req_i  (rst_req_i),
    .rst_kind_i (rst_kind_i),
    .trap_req_i (trap_req_i),
    .trap_ret_i (trap_ret_i),
    .tl_o       (tl_o),
    .red_o      (red_o),
    .err_o      (err_o),
    .vec_take_o (vec_take_o),
    .immu_en_o  (immu_en_o),
    .dmmu_en_o  (dmmu_en_o)
);

// File: tb/trapmode_ctrl_tb_top.sv
module trapmode_ctrl_tb_top;

    localparam int MAX_TL = 5;
    localparam int VA_W   = 64;
    localparam int PA_W   = 43;
    localparam int TL_W   = $clog2(MAX_TL + 1);
    localparam logic [63:0] VA_B = {36'hF_FFFF_FFFF, 28'h0};
    localparam logic [63:0] PA_B = {21'h0, 15'h7FFF, 28'h0};
    localparam logic [63:0] TBA  = 64'h0000_0000_1000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rst_req = 1'b0;
    logic [1:0]      rst_kind = 2'd0;
    logic            trap_req = 1'b0;
    logic            trap_ret = 1'b0;
    logic [VA_W-1:0] tba = TBA;
    logic            sw_immu = 1'b1;
    logic            sw_dmmu = 1'b1;
    logic            dxl_wr = 1'b0;
    logic            dxl_wdata = 1'b0;
    logic [TL_W-1:0] tl;
    logic            red, err, take, immu, dmmu, ncso;
    logic [VA_W-1:0] va;
    logic [PA_W-1:0] pa;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trapmode_ctrl #(.MAX_TL(MAX_TL), .VA_W(VA_W), .PA_W(PA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .rst_kind_i(rst_kind),
        .trap_req_i(trap_req), .trap_ret_i(trap_ret), .tba_i(tba),
        .sw_immu_en_i(sw_immu), .sw_dmmu_en_i(sw_dmmu),
        .dxl_wr_i(dxl_wr), .dxl_wdata_i(dxl_wdata),
        .tl_o(tl), .red_o(red), .err_o(err), .vec_take_o(take),
        .vec_va_o(va), .vec_pa_o(pa),
        .immu_en_o(immu), .dmmu_en_o(dmmu), .ncso_o(ncso)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        rst_req = 1'b0; trap_req = 1'b0; trap_ret = 1'b0; dxl_wr = 1'b0;
    endtask

    task automatic state_chk(input string req, input bit e_red, input bit e_err, input int e_tl);
        check(req, "red", 64'(red), 64'(e_red));
        check(req, "err", 64'(err), 64'(e_err));
        check(req, "tl",  64'(tl),  64'(e_tl));
    endtask

    task automatic do_rst(input logic [1:0] kind);
        rst_req = 1'b1; rst_kind = kind; cyc(); clear_in();
    endtask

    task automatic do_trap();
        trap_req = 1'b1; cyc(); clear_in();
    endtask

    task automatic do_ret();
        trap_ret = 1'b1; cyc(); clear_in();
    endtask

    task automatic do_wr(input logic v);
        dxl_wr = 1'b1; dxl_wdata = v; cyc(); clear_in();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        state_chk("R1", 1, 0, MAX_TL);
        check("R1", "va", va, VA_B + 64'h20);
        check("R1", "pa", 64'(pa), PA_B + 64'h20);
        check("R1", "take", 64'(take), 0);
        check("R8", "immu reset", 64'(immu), 0);
        check("R1", "dmmu", 64'(dmmu), 0);
        check("R10", "ncso reset", 64'(ncso), 1);
    endtask

    task automatic t_ret();
        do_ret();
        state_chk("R7", 0, 0, MAX_TL - 1);
        check("R11", "immu restored", 64'(immu), 1);
        check("R11", "dmmu restored", 64'(dmmu), 1);
        check("R10", "ncso off", 64'(ncso), 0);
        for (int i = 0; i < MAX_TL - 1; i++) do_ret();
        state_chk("R7", 0, 0, 0);
        do_ret();
        state_chk("R7", 0, 0, 0);
        check("R7", "take on ignored ret", 64'(take), 0);
    endtask

    task automatic t_trap_run();
        do_trap();
        state_chk("R2", 0, 0, 1);
        check("R2", "take", 64'(take), 1);
        check("R2", "va level0", va, TBA);
        check("R2", "pa", 64'(pa), 0);
        cyc();
        check("R2", "take pulse end", 64'(take), 0);
        do_trap();
        state_chk("R2", 0, 0, 2);
        check("R2", "va nested", va, TBA + 64'h4000);
        sw_immu = 1'b0; #1;
        check("R8", "immu follows sw", 64'(immu), 0);
        sw_immu = 1'b1; #1;
        check("R8", "immu follows sw", 64'(immu), 1);
    endtask

    task automatic t_xlate();
        do_rst(2'd3);
        state_chk("R5", 1, 0, MAX_TL);
        check("R5", "va sir", va, VA_B + 64'h80);
        check("R5", "pa sir", 64'(pa), PA_B + 64'h80);
        check("R9", "dmmu entry", 64'(dmmu), 0);
        check("R10", "ncso entry", 64'(ncso), 1);
        do_wr(1'b1);
        check("R9", "dmmu reenabled", 64'(dmmu), 1);
        check("R10", "ncso reenabled", 64'(ncso), 0);
        check("R8", "immu in red", 64'(immu), 0);
        do_wr(1'b0);
        check("R9", "dmmu reforced", 64'(dmmu), 0);
        do_wr(1'b1);
        do_rst(2'd2);
        check("R5", "va xir in red", va, VA_B + 64'h60);
        state_chk("R5", 1, 0, MAX_TL);
        check("R9", "reenable cleared", 64'(dmmu), 0);
        do_wr(1'b1);
        sw_dmmu = 1'b0; #1;
        check("R9", "dmmu follows sw", 64'(dmmu), 0);
        sw_dmmu = 1'b1; #1;
        do_wr(1'b0);
        do_ret();
        state_chk("R11", 0, 0, MAX_TL - 1);
        check("R11", "dmmu after exit", 64'(dmmu), 1);
        check("R11", "immu after exit", 64'(immu), 1);
    endtask

    task automatic t_trap_max_err();
        do_trap();
        state_chk("R2", 0, 0, MAX_TL);
        do_trap();
        state_chk("R3", 0, 1, MAX_TL);
        check("R3", "no vector", 64'(take), 0);
        check("R9", "dmmu in err", 64'(dmmu), 0);
    endtask

    task automatic t_err_sticky();
        do_trap();
        state_chk("R4", 0, 1, MAX_TL);
        do_ret();
        state_chk("R4", 0, 1, MAX_TL);
        do_rst(2'd1);
        state_chk("R4", 0, 1, MAX_TL);
        do_rst(2'd3);
        state_chk("R4", 0, 1, MAX_TL);
        check("R8", "immu in err", 64'(immu), 0);
        do_rst(2'd0);
        state_chk("R4", 1, 0, MAX_TL);
        check("R4", "va por", va, VA_B + 64'h20);
        do_trap();
        state_chk("R3", 0, 1, MAX_TL);
        do_rst(2'd2);
        state_chk("R4", 1, 0, MAX_TL);
        check("R4", "va xir", va, VA_B + 64'h60);
    endtask

    task automatic t_priority();
        do_ret();
        trap_req = 1'b1; trap_ret = 1'b1; cyc(); clear_in();
        state_chk("R6", 0, 0, MAX_TL);
        check("R6", "trap over ret take", 64'(take), 1);
        do_ret();
        rst_req = 1'b1; rst_kind = 2'd1; trap_req = 1'b1; trap_ret = 1'b1;
        cyc(); clear_in();
        state_chk("R6", 1, 0, MAX_TL);
        check("R6", "va wdr", va, VA_B + 64'h40);
        check("R6", "pa wdr", 64'(pa), PA_B + 64'h40);
    endtask

    initial begin
        t_reset();
        t_ret();
        t_trap_run();
        t_xlate();
        t_trap_max_err();
        t_err_sticky();
        t_priority();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule